// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a data-out line and a data-in line. Both lines are timed by one shared synchronization clock. The clock is either made inside the block by a programmable divider and driven out with its output enable raised, or it is taken in from an external master on the clock input. Characters go out least significant bit first. Outgoing data changes on a falling clock edge, and incoming data is sampled on a rising edge. No parity or address bit is ever added or checked.

The host writes characters into a one-deep transmit buffer and reads them from a one-deep receive buffer. Both buffers sit in front of their shift registers, so the host can supply the next character, or collect the last one, while a shift is in progress. A character that is waiting in the transmit buffer when the previous one ends follows it without a pause. A character that arrives while the receive buffer is still unread is dropped, and the overrun flag is raised.

Top module: `sync_serial_port`

## Requirements
- R1: Every character is 8 bits, sent least significant bit first. In internal mode `txd` changes only on the system clock edge on which `sck_o` falls.
- R2: On each rising synchronization edge the receiver shifts in one bit, least significant bit first. After the 8th bit the character appears on `rx_data` and `rx_full` goes to 1.
- R3: After the last bit of a character, `txd` keeps the value of bit 7 until the next character starts. After reset `txd` is 1.
- R4: In internal mode (`clk_sel_ext`=0), `sck_oe` is 1 and `sck_o` gives exactly 8 low pulses per character. Whenever no character is shifting, `sck_o` stays high.
- R5: In internal mode, each low phase and each high phase inside a transfer lasts `div_val` system clocks. A `div_val` of 0 acts as 1.
- R6: In external mode (`clk_sel_ext`=1), `sck_oe` is 0 and `sck_o` is 1. Shifting follows the falling and rising edges of `sck_i`, which pass through a two-stage synchronizer. `rxd` is synchronized the same way.
- R7: Transmit and receive run at the same time on the same clock edges. In internal mode, a character received while one is sent is the data on `rxd` during those 8 pulses.
- R8: If the transmit buffer holds a character when the 8th bit of the current one is sampled, the next falling edge comes after a normal high phase. No extra idle time is inserted.
- R9: `tx_empty` is 1 when the transmit buffer can take a character. A `tx_wr` pulse is accepted only while `tx_empty` is 1 and is ignored otherwise. The buffer empties when its character moves into the shift register on a falling edge.
- R10: If a character completes while `rx_full` is 1 and `rx_rd` is low, `rx_ovr` goes to 1, the new character is discarded and `rx_data` keeps the old one. An `rx_rd` pulse clears both `rx_full` and `rx_ovr`.
- R11: After reset, `sck_o`=1, `tx_empty`=1, `rx_full`=0 and `rx_ovr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_sel_ext | input | 1 | 1 selects the external clock, 0 selects the internal divider |
| div_val | input | DIV_W | Half-period of the internal clock, in system clocks |
| sck_i | input | 1 | External synchronization clock |
| sck_o | output | 1 | Synchronization clock output |
| sck_oe | output | 1 | Output enable for `sck_o` |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Character to transmit |
| tx_empty | output | 1 | Transmit buffer can accept a character |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Last character received |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_ovr | output | 1 | A character was lost to a full receive buffer |

## Verification
A bit counter that is off by one shows up at once as a 7th or 9th clock pulse. It also shows as a received byte rotated by one place, which is visible on `rx_data` when the character ends. A divider fault shows as a low or high phase that is not `div_val` cycles long. That is visible on the first pulse of a transfer. A transmit-buffer hand-off fault shows either as a widened high phase between two back-to-back characters or as a lost or duplicated character. Both are visible within 16 pulses. Wrong overrun handling overwrites `rx_data` or leaves `rx_ovr` low. This is seen when the second unread character completes.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel_ext,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             rxd,
  output logic             txd,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_empty,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_full,
  output logic             rx_ovr
);
  localparam int NBITS = 8;
  localparam int BW = $clog2(NBITS);
  localparam logic [BW-1:0] LAST = BW'(NBITS - 1);

  logic [2:0] sck_s;
  logic [1:0] rxd_s;
  logic sck_r;
  logic [DIV_W-1:0] hc, div_m1;
  logic [7:0] tx_buf, tx_sh, rx_sh, rx_buf;
  logic [BW-1:0] tx_bi, rx_bi;
  logic tx_bf, tx_act, txd_r, rx_bf, rx_ov;
  logic hc_done, int_fall, int_rise, fall_ev, rise_ev, rx_bit;
  logic need_load, tx_load, tx_shift;

  assign div_m1   = (div_val == '0) ? '0 : div_val - 1'b1;
  assign hc_done  = hc >= div_m1;
  assign int_fall = !clk_sel_ext && sck_r && (tx_act || tx_bf) && hc_done;
  assign int_rise = !clk_sel_ext && !sck_r && hc_done;
  assign fall_ev  = int_fall || (clk_sel_ext && sck_s[2] && !sck_s[1]);
  assign rise_ev  = int_rise || (clk_sel_ext && !sck_s[2] && sck_s[1]);
  assign rx_bit   = clk_sel_ext ? rxd_s[1] : rxd;

  assign need_load = !tx_act || (tx_bi == LAST);
  assign tx_load   = fall_ev && need_load && tx_bf;
  assign tx_shift  = fall_ev && !need_load;

  assign sck_o    = clk_sel_ext ? 1'b1 : sck_r;
  assign sck_oe   = !clk_sel_ext;
  assign txd      = txd_r;
  assign tx_empty = !tx_bf;
  assign rx_data  = rx_buf;
  assign rx_full  = rx_bf;
  assign rx_ovr   = rx_ov;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '1;
      rxd_s <= '1;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      rxd_s <= {rxd_s[0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r <= 1'b1;
      hc    <= '0;
    end else if (clk_sel_ext) begin
      sck_r <= 1'b1;
      hc    <= '0;
    end else if (int_fall || int_rise) begin
      sck_r <= !sck_r;
      hc    <= '0;
    end else if (!hc_done) begin
      hc <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0;
      tx_bf  <= 1'b0;
      tx_sh  <= '0;
      tx_bi  <= '0;
      tx_act <= 1'b0;
      txd_r  <= 1'b1;
    end else begin
      if (tx_wr && !tx_bf) begin
        tx_buf <= tx_data;
        tx_bf  <= 1'b1;
      end
      if (tx_load) begin
        txd_r  <= tx_buf[0];
        tx_sh  <= tx_buf >> 1;
        tx_bi  <= '0;
        tx_act <= 1'b1;
        tx_bf  <= 1'b0;
      end else if (tx_shift) begin
        txd_r <= tx_sh[0];
        tx_sh <= tx_sh >> 1;
        tx_bi <= tx_bi + 1'b1;
      end
      if (rise_ev && tx_act && tx_bi == LAST && !tx_bf)
        tx_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh  <= '0;
      rx_bi  <= '0;
      rx_buf <= '0;
      rx_bf  <= 1'b0;
      rx_ov  <= 1'b0;
    end else begin
      if (rx_rd) begin
        rx_bf <= 1'b0;
        rx_ov <= 1'b0;
      end
      if (rise_ev) begin
        rx_sh <= {rx_bit, rx_sh[7:1]};
        rx_bi <= (rx_bi == LAST) ? '0 : rx_bi + 1'b1;
        if (rx_bi == LAST) begin
          if (rx_bf && !rx_rd) begin
            rx_ov <= 1'b1;
          end else begin
            rx_buf <= {rx_bit, rx_sh[7:1]};
            rx_bf  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module sync_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_sel_ext,
  input logic       sck_o,
  input logic       txd,
  input logic       tx_wr,
  input logic       tx_empty,
  input logic       rx_rd,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       rx_ovr
);
  // R1
  txd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel_ext && $past(!clk_sel_ext) && !$fell(sck_o)) |-> $stable(txd));
  // R9
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_empty) |=> !tx_empty);
  // R10
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> rx_full);
  // R10
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $stable(rx_data));
  // R10
  rd_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !rx_ovr);
endmodule

bind sync_serial_port sync_serial_port_chk chk_i (.*);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_sel_ext = 1'b0, sck_i = 1'b1, rxd_drv = 1'b1, loop = 1'b1;
  logic [7:0] div_val = 8'd3, tx_data = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic sck_o, sck_oe, txd, tx_empty, rx_full, rx_ovr, rxd;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;

  always #10 clk = !clk;
  assign rxd = loop ? txd : rxd_drv;

  sync_serial_port #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel_ext(clk_sel_ext), .div_val(div_val),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .rxd(rxd), .txd(txd),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr));

  // Observer of the internal clock, sampled away from the active edge
  int falls, hi_run, lo_run, max_hi, min_lo, max_lo;
  logic prev_sck = 1'b1;
  logic [31:0] cap;
  always @(negedge clk) begin
    if (rst_n && !clk_sel_ext) begin
      if (prev_sck && !sck_o) begin
        if (falls > 0 && hi_run > max_hi) max_hi = hi_run;
        falls = falls + 1;
        cap = {txd, cap[31:1]};
        lo_run = 1;
      end else if (!prev_sck && sck_o) begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
        hi_run = 1;
      end else if (sck_o) hi_run = hi_run + 1;
      else lo_run = lo_run + 1;
      prev_sck = sck_o;
    end
  end

  task automatic clr_mon();
    falls = 0; hi_run = 0; lo_run = 0; max_hi = 0; min_lo = 1000; max_lo = 0; cap = '0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_empty();
    do @(negedge clk); while (!tx_empty);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 sck_o", sck_o, 1);
    chk("R11 tx_empty", tx_empty, 1);
    chk("R11 rx_full", rx_full, 0);
    chk("R11 rx_ovr", rx_ovr, 0);
    chk("R3 txd idle", txd, 1);
    chk("R4 sck_oe", sck_oe, 1);
  endtask

  task automatic t_single();
    div_val = 8'd3; loop = 1'b1; clr_mon();
    wr(8'h3C);
    repeat (120) @(negedge clk);
    chk("R4 pulse count", falls, 8);
    chk("R1 lsb first", cap[31:24], 8'h3C);
    chk("R5 low phase min", min_lo, 3);
    chk("R5 low phase max", max_lo, 3);
    chk("R5 high phase", max_hi, 3);
    chk("R4 idle high", sck_o, 1);
    chk("R3 msb hold", txd, 0);
    chk("R2 rx_full", rx_full, 1);
    chk("R2 rx_data", rx_data, 8'h3C);
    chk("R9 empty after", tx_empty, 1);
    rd();
    chk("R10 read clears full", rx_full, 0);
  endtask

  task automatic t_gapless();
    div_val = 8'd2; loop = 1'b1; clr_mon();
    wr(8'h81);
    wait_empty();
    wr(8'h7E);
    chk("R9 full after write", tx_empty, 0);
    wr(8'hFF);
    do @(negedge clk); while (!rx_full);
    chk("R2 first byte", rx_data, 8'h81);
    rd();
    repeat (120) @(negedge clk);
    chk("R8 pulse count", falls, 16);
    chk("R8 first char", cap[23:16], 8'h81);
    chk("R9 second char kept, third ignored", cap[31:24], 8'h7E);
    chk("R8 no gap", max_hi, 2);
    chk("R7 duplex rx", rx_data, 8'h7E);
    chk("R7 no overrun", rx_ovr, 0);
    rd();
  endtask

  task automatic t_overrun();
    div_val = 8'd1; loop = 1'b1; clr_mon();
    wr(8'h11);
    wait_empty();
    wr(8'h22);
    repeat (60) @(negedge clk);
    chk("R10 ovr set", rx_ovr, 1);
    chk("R10 full kept", rx_full, 1);
    chk("R10 old data kept", rx_data, 8'h11);
    chk("R3 msb hold 0x22", txd, 0);
    rd();
    chk("R10 ovr cleared", rx_ovr, 0);
    chk("R10 full cleared", rx_full, 0);
  endtask

  task automatic t_div_zero();
    div_val = 8'd0; loop = 1'b1; clr_mon();
    wr(8'hD5);
    repeat (60) @(negedge clk);
    chk("R5 zero low", max_lo, 1);
    chk("R5 zero high", max_hi, 1);
    chk("R4 count", falls, 8);
    chk("R3 msb hold 1", txd, 1);
    chk("R2 data D5", rx_data, 8'hD5);
    rd();
  endtask

  task automatic t_external();
    logic [7:0] got = '0;
    logic [7:0] rpat = 8'h96;
    clk_sel_ext = 1'b1; loop = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 sck_oe", sck_oe, 0);
    chk("R6 sck_o high", sck_o, 1);
    wr(8'h3C);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_i = 1'b0; rxd_drv = rpat[i];
      repeat (8) @(negedge clk);
      got[i] = txd;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk("R6 tx bits", got, 8'h3C);
    chk("R7 rx data", rx_data, 8'h96);
    chk("R6 rx full", rx_full, 1);
    chk("R3 msb hold ext", txd, 0);
    chk("R9 empty ext", tx_empty, 1);
    rd();
    clk_sel_ext = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (10) @(negedge clk);
    t_single();
    t_gapless();
    t_overrun();
    t_div_zero();
    t_external();
    finish_run();
  end
endmodule